// File: doc/BRIEF.md
# Synchronous burst SRAM array

A cycle-level, synthesizable model of a single-port synchronous static RAM with an internal burst counter. The nominal part holds half a million 18-bit words. Here the address width is a parameter, so a simulation can use a small array. Each word holds two 9-bit lanes. The top bit of each lane is normally used as a parity bit, but the array stores it as plain data.

An access starts on a rising clock edge when one of two active-low start strobes is low and the three chip-select inputs agree. The two strobes differ in when write data is taken. The "now" strobe takes the write data and write enables on the same edge as the address. The "late" strobe takes only the address on its edge, and the write data and enables arrive on the next edge. Once an access has started, the device stays active. On every later edge it either reads or writes the current burst address.

The burst counter is two bits wide. It steps on each edge while the advance input is low and holds while that input is high. Addresses wrap inside the aligned group of four words, in linear or interleaved order. A parameter sets the read latency: flow-through timing or pipelined timing. The data port is split into a data input, a data output and an output-valid flag that a pad driver would use.

Top module: `burst_sram`

## Requirements
- R1: A new access starts at a rising edge only when `start_now_n` is low, or when `start_late_n` is low with `sel_n` low. With no access started and the device idle, write enables and data have no effect on the array.
- R2: An access started by `start_now_n` takes the address, `din` and the write enables on that same edge, and writes the addressed word.
- R3: An access started by `start_late_n` never writes on its start edge. A write takes place on the following edge, at the start address, when the write enables are asserted there with `din`.
- R4: A read performed at edge k is valid at the outputs after edge k when `PIPELINED` is 0. It is valid only after edge k+1 when `PIPELINED` is 1.
- R5: On an edge with no new start while the device is active, `advance_n` low steps the burst counter by one before the access. `advance_n` high holds the counter, so the same word is accessed again.
- R6: With `interleave` low, the two low address bits follow start+count modulo 4. The upper address bits stay fixed, so a burst wraps inside its aligned group of four.
- R7: With `interleave` high, the two low address bits are the start low bits XOR the count.
- R8: `wr_all_n` low writes all 18 bits, whatever the lane controls are. Otherwise, `wr_lane_en_n` low writes lane 0 (bits 8:0) when `lane_wr_n[0]` is low, and lane 1 (bits 17:9) when `lane_wr_n[1]` is low. Lanes not written keep their contents.
- R9: A start with `sel_n` high, `sel_hi` low or `sel2_n` high makes the device idle. It writes nothing, and `dout_en` stays low until the next selected start has reached the output.
- R10: `start_late_n` low while `sel_n` is high is not a start. An active burst carries on as if the strobe were high.
- R11: `dout_en` is high only when a selected read result is present and `out_en_n` is low. While `dout_en` is low, `dout` is zero.
- R12: During and after reset the device is idle, with `dout_en` low and `dout` zero, until a selected access starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all sampling on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | ADDR_W | Word address taken at a start |
| start_late_n | input | 1 | Start strobe, write data one edge after the address |
| start_now_n | input | 1 | Start strobe, write data on the address edge |
| advance_n | input | 1 | Low steps the burst counter |
| sel_n | input | 1 | Active-low select; also gates the late strobe |
| sel_hi | input | 1 | Active-high select |
| sel2_n | input | 1 | Second active-low select |
| interleave | input | 1 | Burst order: 0 linear, 1 interleaved |
| wr_all_n | input | 1 | Whole-word write enable |
| wr_lane_en_n | input | 1 | Enables the per-lane write strobes |
| lane_wr_n | input | LANES | Per-lane write strobes, bit 0 for bits 8:0 |
| out_en_n | input | 1 | Output enable |
| din | input | WORD_W | Write data |
| dout | output | WORD_W | Read data, zero when not valid |
| dout_en | output | 1 | Read data valid and driven |

## Verification
The stepping and hold properties assume that `interleave` is static between two consecutive edges, and they only fire when it is. The bench changes the order input only between bursts, never within one. The properties also assume that the inputs carry no unknown values after reset, so the bench drives every input to a defined level from time zero. The select inputs change only at a falling clock edge. The bench drives every start from idle defaults, and in every deselect case exactly one select input is moved to its off state.

// File: rtl/burst_sram_pkg.sv
package burst_sram_pkg;

  localparam int LANE_CNT = 2;

  // Low two address bits for a given burst count.
  function automatic logic [1:0] burst_offset(input logic [1:0] start,
                                              input logic [1:0] count,
                                              input logic       interleave);
    return interleave ? (start ^ count) : (start + count);
  endfunction

endpackage

// File: rtl/bsr_ctrl.sv
module bsr_ctrl #(
  parameter int ADDR_W = 6,
  parameter int LANES  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              start_late_n,
  input  logic              start_now_n,
  input  logic              advance_n,
  input  logic              sel_n,
  input  logic              sel_hi,
  input  logic              sel2_n,
  input  logic              interleave,
  input  logic              wr_all_n,
  input  logic              wr_lane_en_n,
  input  logic [LANES-1:0]  lane_wr_n,
  output logic              acc_en_o,
  output logic [ADDR_W-1:0] acc_addr_o,
  output logic [LANES-1:0]  acc_we_o
);
  import burst_sram_pkg::*;

  logic              active_q, active_nx;
  logic [ADDR_W-1:0] base_q, base_nx;
  logic [1:0]        count_q, count_nx;
  logic              late_ok, start, chosen;
  logic [LANES-1:0]  lane_req;

  always_comb begin
    late_ok   = !start_late_n && !sel_n;
    start     = late_ok || !start_now_n;
    chosen    = !sel_n && sel_hi && !sel2_n;
    if (!wr_all_n)          lane_req = '1;
    else if (!wr_lane_en_n) lane_req = ~lane_wr_n;
    else                    lane_req = '0;

    active_nx  = active_q;
    base_nx    = base_q;
    count_nx   = count_q;
    acc_en_o   = 1'b0;
    acc_we_o   = '0;
    acc_addr_o = base_q;

    if (rst) begin
      active_nx = 1'b0;
    end else if (start) begin
      active_nx = chosen;
      if (chosen) begin
        base_nx    = addr_i;
        count_nx   = 2'd0;
        acc_en_o   = 1'b1;
        acc_addr_o = addr_i;
        acc_we_o   = late_ok ? '0 : lane_req;
      end
    end else if (active_q) begin
      count_nx   = count_q + {1'b0, !advance_n};
      acc_en_o   = 1'b1;
      acc_addr_o = {base_q[ADDR_W-1:2], burst_offset(base_q[1:0], count_nx, interleave)};
      acc_we_o   = lane_req;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      active_q <= 1'b0;
      base_q   <= '0;
      count_q  <= 2'd0;
    end else begin
      active_q <= active_nx;
      base_q   <= base_nx;
      count_q  <= count_nx;
    end
  end

endmodule

// File: rtl/bsr_array.sv
module bsr_array #(
  parameter int ADDR_W = 6,
  parameter int WORD_W = 18,
  parameter int LANES  = 2
) (
  input  logic              clk,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [LANES-1:0]  acc_we,
  input  logic [WORD_W-1:0] wdata,
  output logic [WORD_W-1:0] rdata
);
  localparam int DEPTH  = 1 << ADDR_W;
  localparam int LANE_W = WORD_W / LANES;

  logic [WORD_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    for (int l = 0; l < LANES; l++) begin
      if (acc_we[l])
        mem[acc_addr][l*LANE_W +: LANE_W] <= wdata[l*LANE_W +: LANE_W];
    end
  end

  always_ff @(posedge clk) begin
    if (rd_en) rdata <= mem[acc_addr];
  end

endmodule

// File: rtl/bsr_rdpipe.sv
module bsr_rdpipe #(
  parameter int WORD_W    = 18,
  parameter bit PIPELINED = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_en,
  input  logic [WORD_W-1:0] rdata_i,
  output logic [WORD_W-1:0] data_o,
  output logic              valid_o
);
  logic stage1_v;

  always_ff @(posedge clk) begin
    if (rst) stage1_v <= 1'b0;
    else     stage1_v <= rd_en;
  end

  generate
    if (PIPELINED) begin : g_pipe
      logic              stage2_v;
      logic [WORD_W-1:0] stage2_q;
      always_ff @(posedge clk) begin
        if (rst) begin
          stage2_v <= 1'b0;
          stage2_q <= '0;
        end else begin
          stage2_v <= stage1_v;
          stage2_q <= rdata_i;
        end
      end
      assign data_o  = stage2_q;
      assign valid_o = stage2_v;
    end else begin : g_flow
      assign data_o  = rdata_i;
      assign valid_o = stage1_v;
    end
  endgenerate

endmodule

// File: rtl/burst_sram.sv
module burst_sram #(
  parameter int ADDR_W    = 6,
  parameter int WORD_W    = 18,
  parameter int LANES     = burst_sram_pkg::LANE_CNT,
  parameter bit PIPELINED = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              start_late_n,
  input  logic              start_now_n,
  input  logic              advance_n,
  input  logic              sel_n,
  input  logic              sel_hi,
  input  logic              sel2_n,
  input  logic              interleave,
  input  logic              wr_all_n,
  input  logic              wr_lane_en_n,
  input  logic [LANES-1:0]  lane_wr_n,
  input  logic              out_en_n,
  input  logic [WORD_W-1:0] din,
  output logic [WORD_W-1:0] dout,
  output logic              dout_en
);
  logic              acc_en;
  logic [ADDR_W-1:0] acc_addr;
  logic [LANES-1:0]  acc_we;
  logic              rd_en;
  logic [WORD_W-1:0] arr_q;
  logic [WORD_W-1:0] pipe_data;
  logic              pipe_valid;

  bsr_ctrl #(.ADDR_W(ADDR_W), .LANES(LANES)) u_ctrl (
    .clk(clk), .rst(rst), .addr_i(addr),
    .start_late_n(start_late_n), .start_now_n(start_now_n),
    .advance_n(advance_n), .sel_n(sel_n), .sel_hi(sel_hi), .sel2_n(sel2_n),
    .interleave(interleave), .wr_all_n(wr_all_n), .wr_lane_en_n(wr_lane_en_n),
    .lane_wr_n(lane_wr_n), .acc_en_o(acc_en), .acc_addr_o(acc_addr),
    .acc_we_o(acc_we)
  );

  assign rd_en = acc_en && (acc_we == '0);

  bsr_array #(.ADDR_W(ADDR_W), .WORD_W(WORD_W), .LANES(LANES)) u_array (
    .clk(clk), .rd_en(rd_en), .acc_addr(acc_addr), .acc_we(acc_we),
    .wdata(din), .rdata(arr_q)
  );

  bsr_rdpipe #(.WORD_W(WORD_W), .PIPELINED(PIPELINED)) u_rdpipe (
    .clk(clk), .rst(rst), .rd_en(rd_en), .rdata_i(arr_q),
    .data_o(pipe_data), .valid_o(pipe_valid)
  );

  assign dout_en = pipe_valid && !out_en_n;
  assign dout    = dout_en ? pipe_data : '0;

endmodule

// File: rtl/burst_sram_chk.sv
module burst_sram_chk #(
  parameter int ADDR_W    = 6,
  parameter int WORD_W    = 18,
  parameter int LANES     = 2,
  parameter bit PIPELINED = 1'b1
) (
  input logic              clk,
  input logic              rst,
  input logic              start_late_n,
  input logic              start_now_n,
  input logic              advance_n,
  input logic              sel_n,
  input logic              sel_hi,
  input logic              sel2_n,
  input logic              interleave,
  input logic              out_en_n,
  input logic [WORD_W-1:0] dout,
  input logic              dout_en,
  input logic              acc_en,
  input logic [ADDR_W-1:0] acc_addr,
  input logic [LANES-1:0]  acc_we
);
  localparam int LAT = PIPELINED ? 2 : 1;

  logic no_start;
  assign no_start = start_now_n && (start_late_n || sel_n);

  AST_OE_GATES: assert property (@(posedge clk) disable iff (rst)
    out_en_n |-> !dout_en); // R11

  AST_QUIET_BUS: assert property (@(posedge clk) disable iff (rst)
    !dout_en |-> (dout == '0)); // R11

  AST_DESEL_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    (!start_now_n && !(!sel_n && sel_hi && !sel2_n)) |-> (acc_we == '0)); // R9

  AST_LATE_START_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    (!start_late_n && !sel_n) |-> (acc_we == '0)); // R3

  AST_SUSPEND_HOLD: assert property (@(posedge clk) disable iff (rst)
    (acc_en && $past(acc_en) && no_start && advance_n && $stable(interleave))
    |-> (acc_addr == $past(acc_addr))); // R5

  AST_LINEAR_STEP: assert property (@(posedge clk) disable iff (rst)
    (acc_en && $past(acc_en) && no_start && !advance_n && !interleave && $stable(interleave))
    |-> ((acc_addr[1:0] == $past(acc_addr[1:0]) + 2'd1) &&
         (acc_addr[ADDR_W-1:2] == $past(acc_addr[ADDR_W-1:2])))); // R6

  AST_READ_LATENCY: assert property (@(posedge clk) disable iff (rst)
    dout_en |-> $past(acc_en && (acc_we == '0), LAT)); // R4

endmodule

bind burst_sram burst_sram_chk #(
  .ADDR_W(ADDR_W), .WORD_W(WORD_W), .LANES(LANES), .PIPELINED(PIPELINED)
) u_chk (
  .clk(clk), .rst(rst), .start_late_n(start_late_n), .start_now_n(start_now_n),
  .advance_n(advance_n), .sel_n(sel_n), .sel_hi(sel_hi), .sel2_n(sel2_n),
  .interleave(interleave), .out_en_n(out_en_n), .dout(dout), .dout_en(dout_en),
  .acc_en(acc_en), .acc_addr(acc_addr), .acc_we(acc_we)
);

// File: tb/tb_burst_sram.sv
module tb_burst_sram;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 6;
  localparam int DW = 18;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [AW-1:0] addr = '0;
  logic          s_late_n = 1'b1, s_now_n = 1'b1, adv_n = 1'b1;
  logic          sel_n = 1'b0, sel_hi = 1'b1, sel2_n = 1'b0, il = 1'b0;
  logic          wr_all_n = 1'b1, wr_lane_en_n = 1'b1;
  logic [1:0]    lane_wr_n = 2'b11;
  logic          oe_n = 1'b0;
  logic [DW-1:0] din = '0;
  logic [DW-1:0] dout_p, dout_f;
  logic          en_p, en_f;

  int checks = 0;
  int errors = 0;
  logic [DW-1:0] ref_mem [64];

  always #(CLK_PERIOD/2) clk = ~clk;

  burst_sram #(.ADDR_W(AW), .WORD_W(DW), .LANES(2), .PIPELINED(1'b1)) dut (
    .clk(clk), .rst(rst), .addr(addr), .start_late_n(s_late_n), .start_now_n(s_now_n),
    .advance_n(adv_n), .sel_n(sel_n), .sel_hi(sel_hi), .sel2_n(sel2_n),
    .interleave(il), .wr_all_n(wr_all_n), .wr_lane_en_n(wr_lane_en_n),
    .lane_wr_n(lane_wr_n), .out_en_n(oe_n), .din(din), .dout(dout_p), .dout_en(en_p)
  );

  burst_sram #(.ADDR_W(AW), .WORD_W(DW), .LANES(2), .PIPELINED(1'b0)) dut_ft (
    .clk(clk), .rst(rst), .addr(addr), .start_late_n(s_late_n), .start_now_n(s_now_n),
    .advance_n(adv_n), .sel_n(sel_n), .sel_hi(sel_hi), .sel2_n(sel2_n),
    .interleave(il), .wr_all_n(wr_all_n), .wr_lane_en_n(wr_lane_en_n),
    .lane_wr_n(lane_wr_n), .out_en_n(oe_n), .din(din), .dout(dout_f), .dout_en(en_f)
  );

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic chk_bit(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  function automatic logic [AW-1:0] baddr(input logic [AW-1:0] b, input logic [1:0] s,
                                          input logic ilv);
    logic [1:0] lo;
    lo = ilv ? (b[1:0] ^ s) : (b[1:0] + s);
    return {b[AW-1:2], lo};
  endfunction

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic idle();
    s_late_n = 1'b1; s_now_n = 1'b1; adv_n = 1'b1;
    sel_n = 1'b0; sel_hi = 1'b1; sel2_n = 1'b0;
    wr_all_n = 1'b1; wr_lane_en_n = 1'b1; lane_wr_n = 2'b11;
  endtask

  task automatic desel();
    s_now_n = 1'b0; sel_n = 1'b1;
    tick();
    idle();
  endtask

  // Single-edge write through the "now" strobe; reference updated per R8.
  task automatic wr_now(input logic [AW-1:0] a, input logic [DW-1:0] d,
                        input logic all_n, input logic len_n, input logic [1:0] ln_n);
    s_now_n = 1'b0; addr = a; din = d;
    wr_all_n = all_n; wr_lane_en_n = len_n; lane_wr_n = ln_n;
    tick();
    idle();
    if (!all_n) ref_mem[a] = d;
    else if (!len_n) begin
      if (!ln_n[0]) ref_mem[a][8:0]  = d[8:0];
      if (!ln_n[1]) ref_mem[a][17:9] = d[17:9];
    end
  endtask

  task automatic read_single(input logic [AW-1:0] a, input string req);
    desel();
    s_late_n = 1'b0; addr = a;
    tick();
    idle();
    chk_bit("R4 flow valid", en_f, 1'b1);
    chk(req, dout_f, ref_mem[a]);
    chk_bit("R4 pipe not yet", en_p, 1'b0);
    tick();
    chk_bit("R4 pipe valid", en_p, 1'b1);
    chk(req, dout_p, ref_mem[a]);
  endtask

  task automatic burst_rd(input logic [AW-1:0] b, input logic ilv, input int n,
                          input logic [15:0] advm, input string req);
    logic [1:0]    s;
    logic [DW-1:0] e, prev;
    desel();
    il = ilv; s = 2'd0; prev = '0;
    for (int i = 0; i < n; i++) begin
      if (i == 0) begin s_late_n = 1'b0; addr = b; adv_n = 1'b1; end
      else begin
        s_late_n = 1'b1; adv_n = !advm[i];
        if (advm[i]) s = s + 2'd1;
      end
      tick();
      e = ref_mem[baddr(b, s, ilv)];
      chk(req, dout_f, e);
      if (i > 0) chk(req, dout_p, prev);
      prev = e;
    end
    idle();
    tick();
    chk(req, dout_p, prev);
    il = 1'b0;
  endtask

  task automatic burst_wr(input logic [AW-1:0] b, input logic ilv, input logic [DW-1:0] d0);
    logic [1:0] s;
    s = 2'd0; il = ilv;
    for (int i = 0; i < 4; i++) begin
      if (i == 0) begin s_now_n = 1'b0; addr = b; end
      else begin s_now_n = 1'b1; adv_n = 1'b0; s = s + 2'd1; end
      wr_all_n = 1'b0; din = d0 + DW'(i);
      ref_mem[baddr(b, s, ilv)] = d0 + DW'(i);
      tick();
    end
    idle();
    il = 1'b0;
  endtask

  task automatic t_reset();
    chk_bit("R12 reset flow en", en_f, 1'b0);
    chk_bit("R12 reset pipe en", en_p, 1'b0);
    chk("R12 reset dout", dout_p, '0);
    rst = 1'b0;
    wr_all_n = 1'b0; addr = 6'd3; din = 18'h15555;
    tick(); tick();
    idle();
    chk_bit("R12 idle flow en", en_f, 1'b0);
    chk_bit("R12 idle pipe en", en_p, 1'b0);
  endtask

  task automatic t_now_write();
    for (int a = 0; a < 64; a++) wr_now(AW'(a), DW'(a * 1031 + 7), 1'b0, 1'b1, 2'b11);
    wr_now(6'd5, 18'h2A5A5, 1'b0, 1'b1, 2'b11);
    read_single(6'd5, "R2 now-strobe write");
    read_single(6'd6, "R2 neighbour intact");
  endtask

  task automatic t_late_write();
    desel();
    s_late_n = 1'b0; addr = 6'd9;
    tick();
    s_late_n = 1'b1; wr_all_n = 1'b0; din = 18'h1C3C3;
    tick();
    idle();
    ref_mem[9] = 18'h1C3C3;
    read_single(6'd9, "R3 late write next edge");
    desel();
    s_late_n = 1'b0; addr = 6'd9; wr_all_n = 1'b0; din = 18'h00BAD;
    tick();
    idle();
    tick();
    read_single(6'd9, "R3 start-edge enables ignored");
  endtask

  task automatic t_lanes();
    wr_now(6'd12, 18'h3FFFF, 1'b0, 1'b1, 2'b11);
    wr_now(6'd12, 18'h00000, 1'b1, 1'b0, 2'b10);
    chk("R8 model lane0", ref_mem[12], 18'h3FE00);
    read_single(6'd12, "R8 lane0 only");
    wr_now(6'd13, 18'h3FFFF, 1'b0, 1'b1, 2'b11);
    wr_now(6'd13, 18'h00000, 1'b1, 1'b0, 2'b01);
    read_single(6'd13, "R8 lane1 only");
    wr_now(6'd14, 18'h12345, 1'b0, 1'b0, 2'b11);
    read_single(6'd14, "R8 whole word overrides");
    wr_now(6'd14, 18'h00000, 1'b1, 1'b1, 2'b00);
    read_single(6'd14, "R8 lanes without enable");
  endtask

  task automatic t_bursts();
    burst_rd(6'd17, 1'b0, 8, 16'hFFFF, "R6 linear wrap");
    burst_wr(6'd21, 1'b0, 18'h30000);
    burst_rd(6'd20, 1'b0, 4, 16'hFFFF, "R6 linear burst write");
    burst_rd(6'd16, 1'b0, 7, 16'b1110011, "R5 suspend holds");
    burst_rd(6'd17, 1'b1, 5, 16'hFFFF, "R7 interleave from 1");
    burst_rd(6'd18, 1'b1, 4, 16'hFFFF, "R7 interleave from 2");
    burst_wr(6'd27, 1'b1, 18'h0A000);
    burst_rd(6'd24, 1'b0, 4, 16'hFFFF, "R7 interleaved burst write");
  endtask

  task automatic t_deselect();
    logic [DW-1:0] old5;
    old5 = ref_mem[5];
    s_now_n = 1'b0; sel_n = 1'b1; addr = 6'd5; wr_all_n = 1'b0; din = 18'h0DEAD;
    tick(); idle(); tick();
    chk_bit("R9 flow off", en_f, 1'b0);
    chk_bit("R9 pipe off", en_p, 1'b0);
    s_now_n = 1'b0; sel_hi = 1'b0; addr = 6'd5; wr_all_n = 1'b0; din = 18'h0BEEF;
    tick(); idle();
    s_now_n = 1'b0; sel2_n = 1'b1; addr = 6'd5; wr_all_n = 1'b0; din = 18'h0CAFE;
    tick(); idle();
    wr_all_n = 1'b0; addr = 6'd5; din = 18'h0F00D;
    tick(); idle(); tick();
    chk_bit("R1 idle no output", en_f, 1'b0);
    read_single(6'd5, "R9 R1 no write while deselected");
    chk("R9 value kept", ref_mem[5], old5);
    s_late_n = 1'b0; sel_hi = 1'b0; addr = 6'd5;
    tick(); idle(); tick();
    chk_bit("R9 late deselect flow", en_f, 1'b0);
    chk_bit("R9 late deselect pipe", en_p, 1'b0);
  endtask

  task automatic t_ignore_late();
    desel();
    s_late_n = 1'b0; addr = 6'd16;
    tick();
    s_late_n = 1'b0; sel_n = 1'b1; addr = 6'd40;
    tick();
    chk("R10 burst continues", dout_f, ref_mem[16]);
    adv_n = 1'b0;
    tick();
    idle();
    chk("R10 advances from old base", dout_f, ref_mem[17]);
    chk("R10 pipe old base", dout_p, ref_mem[16]);
  endtask

  task automatic t_oe();
    desel();
    oe_n = 1'b1;
    s_late_n = 1'b0; addr = 6'd9;
    tick(); idle();
    chk_bit("R11 flow gated", en_f, 1'b0);
    chk("R11 flow bus quiet", dout_f, '0);
    tick();
    chk_bit("R11 pipe gated", en_p, 1'b0);
    chk("R11 pipe bus quiet", dout_p, '0);
    oe_n = 1'b0;
    #1;
    chk_bit("R11 pipe enabled", en_p, 1'b1);
    chk("R11 pipe data back", dout_p, ref_mem[9]);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL R12 watchdog actual=timeout expected=completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    idle();
    repeat (3) tick();
    t_reset();
    t_now_write();
    t_late_write();
    t_lanes();
    t_bursts();
    t_deselect();
    t_ignore_late();
    t_oe();
    repeat (2) tick();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule